// File: doc/BRIEF.md
# Fetch Program Counter and Wrong-Path Squash Control

This block produces the fetch address for an in-order pipeline that issues one instruction per cycle. With no predictor, it assumes sequential flow and steps the program counter by one 4-byte instruction every cycle. A branch is resolved in the execute stage, three cycles after its fetch. When execute reports a taken branch, the block switches the fetch address to the branch target in that same cycle. It also marks the two younger instructions already in flight as invalid, because they were fetched from the wrong path.

The block does not compare branch operands. The execute stage supplies a raw taken flag, the target address (instruction address plus its sign-extended immediate) and a raw register-write request. The block returns qualified versions of the flag and the request. A squashed instruction, or one that is still draining the empty pipeline after reset, can therefore neither redirect fetch nor write the register file. The instruction memory receives a read enable and a word address taken from the program counter.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `imem_rd_en_o`, `ex_valid_o`, `redirect_o` and `rf_we_o` are all 0, whatever the other inputs are.
- R2: In the first cycle after `rst_n` rises, `pc_o` is 0.
- R3: In every later cycle with `redirect_o` low, `pc_o` equals the previous cycle's `pc_o` plus 4, wrapping modulo 2^32.
- R4: In a cycle with `redirect_o` high, `pc_o` equals `br_target_i` in that same cycle. Sequential stepping resumes from the target in the next cycle.
- R5: `imem_rd_en_o` is high exactly when `rst_n` is high, and `imem_addr_o` is `pc_o` bits 9 down to 2 (an 8-bit word index).
- R6: In the two cycles after a cycle with `redirect_o` high, `ex_valid_o` is 0. Exactly two wrong-path instructions are killed, and the third cycle is valid again unless another rule intervenes.
- R7: A taken flag presented while `ex_valid_o` is 0 is ignored: `redirect_o` stays 0 and `pc_o` keeps stepping by 4. For this reason, two taken branches can never redirect in consecutive cycles.
- R8: In the first three cycles after reset release, the execute slot holds no fetched instruction, so `ex_valid_o` is 0. From the fourth cycle on, it is 1 unless R6 applies.
- R9: `redirect_o` equals `br_taken_i` AND `ex_valid_o`. `rf_we_o` equals `rf_wr_req_i` AND `ex_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| br_taken_i | input | 1 | Raw branch-taken flag for the instruction in execute |
| br_target_i | input | 32 | Branch target address computed in execute |
| rf_wr_req_i | input | 1 | Raw register-write request of the instruction in execute |
| pc_o | output | 32 | Address being fetched this cycle |
| imem_addr_o | output | 8 | Instruction memory word address |
| imem_rd_en_o | output | 1 | Instruction memory read enable |
| ex_valid_o | output | 1 | Instruction in execute is on the correct path |
| redirect_o | output | 1 | Qualified taken branch: fetch redirected this cycle |
| rf_we_o | output | 1 | Qualified register-file write enable |

## Verification
The hardest situation to reach is a taken flag that arrives inside a shadow window, such as a second taken branch one or two cycles after a real redirect, or a taken flag while the pipeline is still filling after reset. A correct design must give it no effect at all. The stimulus asserts the raw taken flag and the write request on purpose in both kill cycles after a redirect, and in the warm-up cycles after each of two reset releases. The bench then checks that the fetch address keeps stepping by 4 and that neither qualified output rises. Further redirects cover a target at the top word of the 256-word space and a redirect in the first cycle that becomes valid after a kill window.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned FPC_XLEN      = 32;
  localparam int unsigned FPC_INSN_LG2  = 2;
  localparam int unsigned FPC_INSN_BYTES = 1 << FPC_INSN_LG2;
  typedef logic [FPC_XLEN-1:0] fpc_addr_t;
endpackage

// File: rtl/fpc_pcgen.sv
module fpc_pcgen
  import fpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      redirect_i,
  input  fpc_addr_t target_i,
  output fpc_addr_t pc_o
);
  logic      first_q;
  fpc_addr_t seq_q;
  fpc_addr_t seq_d;
  fpc_addr_t pc_c;

  // next-state: restart at zero, redirect in the resolving cycle, else step
  always_comb begin
    if (first_q)         pc_c = '0;
    else if (redirect_i) pc_c = target_i;
    else                 pc_c = seq_q;
    seq_d = pc_c + fpc_addr_t'(FPC_INSN_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      seq_q   <= '0;
    end else begin
      first_q <= 1'b0;
      seq_q   <= seq_d;
    end
  end

  assign pc_o = pc_c;
endmodule

// File: rtl/fpc_squash.sv
module fpc_squash #(
  parameter int unsigned EX_DIST = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic br_taken_i,
  input  logic wr_req_i,
  output logic valid_o,
  output logic redirect_o,
  output logic we_o
);
  localparam int unsigned KILL = EX_DIST - 1;

  logic [EX_DIST-1:0] fill_q, fill_d;
  logic [KILL-1:0]    kill_q, kill_d;
  logic               valid_c;
  logic               redir_c;

  always_comb begin
    valid_c = fill_q[EX_DIST-1] & ~(|kill_q);
    redir_c = br_taken_i & valid_c;
    fill_d  = {fill_q[EX_DIST-2:0], 1'b1};
  end

  generate
    if (KILL > 1) begin : g_kill_multi
      always_comb kill_d = {kill_q[KILL-2:0], redir_c};
    end else begin : g_kill_single
      always_comb kill_d = redir_c;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      kill_q <= '0;
    end else begin
      fill_q <= fill_d;
      kill_q <= kill_d;
    end
  end

  assign valid_o    = valid_c;
  assign redirect_o = redir_c;
  assign we_o       = wr_req_i & valid_c;
endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned EX_DIST  = 3,
  parameter int unsigned IMEM_AW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_taken_i,
  input  logic [FPC_XLEN-1:0]  br_target_i,
  input  logic                 rf_wr_req_i,
  output logic [FPC_XLEN-1:0]  pc_o,
  output logic [IMEM_AW-1:0]   imem_addr_o,
  output logic                 imem_rd_en_o,
  output logic                 ex_valid_o,
  output logic                 redirect_o,
  output logic                 rf_we_o
);
  localparam int unsigned ADDR_LSB = FPC_INSN_LG2;
  localparam int unsigned ADDR_MSB = ADDR_LSB + IMEM_AW - 1;

  logic      redir_w;
  fpc_addr_t pc_w;

  fpc_squash #(.EX_DIST(EX_DIST)) u_squash (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_taken_i (br_taken_i),
    .wr_req_i   (rf_wr_req_i),
    .valid_o    (ex_valid_o),
    .redirect_o (redir_w),
    .we_o       (rf_we_o)
  );

  fpc_pcgen u_pcgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .redirect_i (redir_w),
    .target_i   (br_target_i),
    .pc_o       (pc_w)
  );

  assign redirect_o   = redir_w;
  assign pc_o         = pc_w;
  assign imem_addr_o  = pc_w[ADDR_MSB:ADDR_LSB];
  assign imem_rd_en_o = rst_n;
endmodule

// File: rtl/fetch_pc_ctrl_chk.sv
module fetch_pc_ctrl_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] br_target_i,
  input logic            redirect_o,
  input logic            ex_valid_o,
  input logic            rf_we_o,
  input logic            imem_rd_en_o
);
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_o && $past(rst_n)) |-> (pc_o == $past(pc_o) + XLEN'(4))); // R3
  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (pc_o == br_target_i)); // R4
  AST_KILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redirect_o) |-> !ex_valid_o); // R6
  AST_KILL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redirect_o, 2) |-> !ex_valid_o); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redirect_o) |-> !redirect_o); // R7
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o || redirect_o) |-> ex_valid_o); // R9
  AST_FETCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd_en_o); // R5
  AST_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !ex_valid_o); // R8
endmodule

bind fetch_pc_ctrl fetch_pc_ctrl_chk #(.XLEN(32)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pc_o         (pc_o),
  .br_target_i  (br_target_i),
  .redirect_o   (redirect_o),
  .ex_valid_o   (ex_valid_o),
  .rf_we_o      (rf_we_o),
  .imem_rd_en_o (imem_rd_en_o)
);

// File: tb/tb_fetch_pc_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_pc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_taken_i;
  logic [31:0] br_target_i;
  logic        rf_wr_req_i;
  logic [31:0] pc_o;
  logic [7:0]  imem_addr_o;
  logic        imem_rd_en_o, ex_valid_o, redirect_o, rf_we_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model state
  int          cyc;
  logic [31:0] prev_pc;
  bit          h1, h2;

  always #5 clk = ~clk;

  fetch_pc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .rf_wr_req_i(rf_wr_req_i), .pc_o(pc_o), .imem_addr_o(imem_addr_o),
    .imem_rd_en_o(imem_rd_en_o), .ex_valid_o(ex_valid_o), .redirect_o(redirect_o),
    .rf_we_o(rf_we_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic reset_check();
    br_taken_i = 1'b1; br_target_i = 32'h0000_0500; rf_wr_req_i = 1'b1;
    #1;
    chk(pc_o == 32'd0,       "R1 pc",       pc_o, 0);
    chk(imem_rd_en_o == 1'b0,"R1 rd_en",    imem_rd_en_o, 0);
    chk(ex_valid_o == 1'b0,  "R1 valid",    ex_valid_o, 0);
    chk(redirect_o == 1'b0,  "R1 redirect", redirect_o, 0);
    chk(rf_we_o == 1'b0,     "R1 we",       rf_we_o, 0);
  endtask

  // one cycle: drive at negedge, check, advance model, wait next negedge
  task automatic step(input bit tk, input logic [31:0] tgt, input bit wr);
    logic [31:0] e_pc;
    bit e_val, e_red, e_we;
    br_taken_i = tk; br_target_i = tgt; rf_wr_req_i = wr;
    #1;
    e_val = (cyc >= 3) && !h1 && !h2;
    e_red = tk && e_val;
    e_we  = wr && e_val;
    if (cyc == 0)  e_pc = 32'd0;
    else if (e_red) e_pc = tgt;
    else           e_pc = prev_pc + 32'd4;
    chk(pc_o == e_pc, (cyc == 0) ? "R2 pc" : (e_red ? "R4 pc" : (tk ? "R7 pc" : "R3 pc")), pc_o, e_pc);
    chk(imem_addr_o == e_pc[9:2], "R5 addr", imem_addr_o, e_pc[9:2]);
    chk(imem_rd_en_o == 1'b1, "R5 rd_en", imem_rd_en_o, 1);
    chk(ex_valid_o == e_val, (cyc < 3) ? "R8 valid" : "R6 valid", ex_valid_o, e_val);
    chk(redirect_o == e_red, e_val ? "R9 redirect" : "R7 redirect", redirect_o, e_red);
    chk(rf_we_o == e_we, e_val ? "R9 we" : "R7 we", rf_we_o, e_we);
    h2 = h1; h1 = e_red; prev_pc = e_pc; cyc++;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; h1 = 0; h2 = 0; prev_pc = 32'd0;
  endtask

  initial begin
    rst_n = 1'b0; br_taken_i = 1'b0; br_target_i = '0; rf_wr_req_i = 1'b0;
    cyc = 0; h1 = 0; h2 = 0; prev_pc = '0;
    repeat (3) @(negedge clk);
    reset_check();
    release_reset();
    for (int c = 0; c < 40; c++) begin
      case (c)
        1:       step(1'b1, 32'h0000_0200, 1'b1); // R8 warm-up taken ignored
        6:       step(1'b1, 32'h0000_0100, 1'b1); // R4 first redirect
        7, 8:    step(1'b1, 32'h0000_0300, 1'b1); // R7 shadow taken ignored
        9:       step(1'b0, 32'h0, 1'b1);         // R9 write after kill window
        12:      step(1'b1, 32'h0000_03FC, 1'b0); // R5 top word address
        15:      step(1'b1, 32'h0000_0020, 1'b0); // R6 first slot after kill
        20:      step(1'b1, 32'h0000_0080, 1'b1);
        22:      step(1'b1, 32'h0000_0600, 1'b1); // R7 second shadow slot
        default: step(1'b0, 32'h0, (c % 3) == 0);
      endcase
    end
    rst_n = 1'b0;
    @(negedge clk);
    reset_check();
    release_reset();
    for (int c = 0; c < 12; c++) begin
      if (c == 2)      step(1'b1, 32'h0000_0700, 1'b1); // R8 after second reset
      else if (c == 4) step(1'b1, 32'h0000_0040, 1'b1); // R4
      else             step(1'b0, 32'h0, 1'b0);
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule